// File: doc/BRIEF.md
# Per-Character Blink Timing Unit

This unit generates the blink rhythm for a character overlay. It counts vertical sync strobes to produce a frame count that repeats every 32 or 64 frames. It compares that count against an on-window whose length is a selectable quarter fraction of the period, and uses the result to gate the foreground dot of each character cell.

Each cell carries one blink attribute bit. A cell with the bit clear is always drawn. A cell with the bit set loses its foreground dots during the off part of the cycle. The cell background is handled elsewhere, so it stays visible. A 3-bit control field selects the period and the duty.

The duty takes effect on the very next pixel. A new period is held back until the running count wraps, so a cycle that is already under way is never cut short or stretched.

Top module: `blink_gate`

## Requirements
- R1: After `rst_ni` is released, the frame count is 0 and the period is 32 frames. With no vsync strobe yet, every cell shows its foreground for any duty.
- R2: When `cell_blink_i` is 0, `fg_pix_o` equals `fg_pix_i` in the same cycle, whatever the control field and frame count are.
- R3: Each cycle with `vsync_i` high advances the frame count by one. The count holds in cycles without the strobe. On the strobe that finds the count at period-1, the count returns to 0.
- R4: Control bit 2 selects the period: 0 means 32 frames and 1 means 64 frames. A change to this bit is adopted only on the strobe that wraps the count to 0.
- R5: When control bits 1:0 are 00, no cell blinks, and `fg_pix_o` equals `fg_pix_i`.
- R6: When control bits 1:0 hold k = 1, 2 or 3 and `cell_blink_i` is 1, `fg_pix_o` is forced to 0 while the frame count is at least k*period/4. Otherwise it equals `fg_pix_i`. This gives on-duties of 25 %, 50 % and 75 %.
- R7: A change to control bits 1:0 affects `fg_pix_o` combinationally, without waiting for a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | One-cycle strobe per frame |
| blink_ctrl_i | input | 3 | Bit 2 selects the period; bits 1:0 select the duty |
| cell_blink_i | input | 1 | Blink attribute bit of the current cell |
| fg_pix_i | input | 1 | Foreground dot of the current cell |
| fg_pix_o | output | 1 | Foreground dot after blink gating |

## Verification
A wrong frame count shows up at the port as foreground suppressed or shown on the wrong frames. The mismatch appears at the latest within one quarter period, which is 8 to 16 strobes. A wrongly latched period moves the off-window edges and the wrap point, so the error shows within one full cycle after the bad adoption. The bench follows every strobe over several hundred frames and crosses two period switches made in the middle of a cycle. On every frame it sweeps all duty codes, attribute values and dot values, so an error in the phase or the adoption of a period is seen in the frame where it first occurs.

// File: rtl/blink_pkg.sv
package blink_pkg;
  typedef enum logic [1:0] {
    DUTY_OFF = 2'b00,
    DUTY_Q1  = 2'b01,
    DUTY_Q2  = 2'b10,
    DUTY_Q3  = 2'b11
  } duty_e;

  typedef struct packed {
    logic  long_sel;
    duty_e duty;
  } blink_ctrl_t;
endpackage

// File: rtl/blink_frame_ctr.sv
module blink_frame_ctr #(
  parameter int SHORT_FRAMES = 32,
  parameter int LONG_FRAMES  = 64,
  localparam int CNT_W = $clog2(LONG_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic             long_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W:0]   len_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic [CNT_W:0]   len;
  logic             last;

  assign len   = long_q ? (CNT_W+1)'(LONG_FRAMES) : (CNT_W+1)'(SHORT_FRAMES);
  assign last  = ({1'b0, cnt_q} == len - 1'b1);
  assign cnt_o = cnt_q;
  assign len_o = len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (vsync_i) begin
      if (last) begin
        cnt_q  <= '0;
        long_q <= long_sel_i;  // period adopted only at wrap
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < len);
  p_wrap_to_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && last) |=> (cnt_q == '0));
  p_hold_no_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(cnt_q));
  p_period_only_at_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vsync_i && last) |=> $stable(long_q));
endmodule

// File: rtl/blink_phase.sv
module blink_phase
  import blink_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   len_i,
  input  duty_e            duty_i,
  output logic             off_phase_o
);
  logic [CNT_W+1:0] quarter;
  logic [CNT_W+1:0] on_len;

  assign quarter = {1'b0, len_i >> 2};
  assign on_len  = quarter * {{CNT_W{1'b0}}, duty_i};
  assign off_phase_o = (duty_i != DUTY_OFF) && ({2'b00, cnt_i} >= on_len);

  p_duty_off_never_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == DUTY_OFF) |-> !off_phase_o);
  p_start_is_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> !off_phase_o);
endmodule

// File: rtl/blink_gate.sv
module blink_gate
  import blink_pkg::*;
#(
  parameter int SHORT_FRAMES = 32,
  parameter int LONG_FRAMES  = 64,
  localparam int CNT_W = $clog2(LONG_FRAMES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vsync_i,
  input  logic [2:0] blink_ctrl_i,
  input  logic       cell_blink_i,
  input  logic       fg_pix_i,
  output logic       fg_pix_o
);
  blink_ctrl_t      ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   len;
  logic             off_phase;

  assign ctrl = blink_ctrl_t'(blink_ctrl_i);

  blink_frame_ctr #(
    .SHORT_FRAMES(SHORT_FRAMES),
    .LONG_FRAMES (LONG_FRAMES)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vsync_i   (vsync_i),
    .long_sel_i(ctrl.long_sel),
    .cnt_o     (cnt),
    .len_o     (len)
  );

  blink_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt),
    .len_i      (len),
    .duty_i     (ctrl.duty),
    .off_phase_o(off_phase)
  );

  assign fg_pix_o = fg_pix_i & ~(cell_blink_i & off_phase);

  p_plain_cell_passes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_blink_i |-> (fg_pix_o == fg_pix_i));
  p_duty_off_passes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_ctrl_i[1:0] == 2'b00) |-> (fg_pix_o == fg_pix_i));
  p_never_adds_dots_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fg_pix_i |-> !fg_pix_o);
endmodule

// File: tb/tb_blink_gate.sv
`timescale 1ns/1ps
module tb_blink_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vsync_i = 1'b0;
  logic [2:0] blink_ctrl_i = 3'b000;
  logic       cell_blink_i = 1'b0;
  logic       fg_pix_i = 1'b0;
  logic       fg_pix_o;

  int checks = 0;
  int errors = 0;
  int m_cnt  = 0;
  int m_len  = 32;
  logic psel = 1'b0;

  blink_gate dut (.*);

  always #2.5 clk_i = ~clk_i;

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired, got hung run, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s frame=%0d len=%0d ctrl=%b blink=%b fg=%b got=%b exp=%b",
               tag, m_cnt, m_len, blink_ctrl_i, cell_blink_i, fg_pix_i, got, exp);
    end
  endtask

  // Sweep all duty/attribute/dot combinations at the current frame count.
  task automatic sweep(input string extra);
    for (int d = 0; d < 4; d++) begin
      for (int b = 0; b < 2; b++) begin
        for (int f = 0; f < 2; f++) begin
          logic exp;
          string tag;
          blink_ctrl_i = {psel, 2'(d)};
          cell_blink_i = 1'(b);
          fg_pix_i     = 1'(f);
          #0.5;
          exp = 1'(f);
          if (b == 1 && d != 0 && m_cnt >= (m_len / 4) * d) exp = 1'b0;
          if (b == 0)      tag = "R2";
          else if (d == 0) tag = "R5";
          else             tag = {"R6 R7 R3 R4 ", extra};
          chk(tag, fg_pix_o, exp);
        end
      end
    end
  endtask

  task automatic frame();
    @(negedge clk_i);
    vsync_i = 1'b1;
    @(posedge clk_i);
    if (m_cnt == m_len - 1) begin
      m_cnt = 0;
      m_len = psel ? 64 : 32;
    end else begin
      m_cnt++;
    end
    @(negedge clk_i);
    vsync_i = 1'b0;
    repeat (2) @(negedge clk_i);  // count must hold without strobe
    sweep("");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    sweep("R1");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    sweep("R1");
    // short period, several wraps
    for (int i = 0; i < 75; i++) frame();
    // request long period mid-cycle; adopted at next wrap
    while (m_cnt != 10) frame();
    psel = 1'b1;
    for (int i = 0; i < 150; i++) frame();
    // back to short mid-cycle of a long period
    while (!(m_len == 64 && m_cnt == 40)) frame();
    psel = 1'b0;
    for (int i = 0; i < 100; i++) frame();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule